// File: doc/BRIEF.md
# Clock Victim Picker

This block picks which physical frame to evict next, using the second-chance clock policy. It stores one usage flag per frame and a single pointer, the hand, that walks the frames in a ring in increasing index order. Whenever a frame is touched, the memory side pulses the reference input with that frame's index, and the frame's flag is set.

When a victim is needed, a one-cycle request starts a sweep at the frame under the hand. The block looks at one frame per clock. A frame whose flag is set loses the flag, and the hand moves on. The first frame found with a clear flag becomes the victim. The block reports it on a registered index output together with a one-cycle done pulse. The hand is then left on the frame after the victim, so the next sweep starts there.

Writing back dirty data, filling frames and updating translation tables are handled outside this block.

Top module: `clock_victim_picker`

## Requirements
- R1: A synchronous active-high reset clears every usage flag, puts the hand on frame 0 and holds the done output low. After reset, the first sweep therefore returns frame 0, even if flags were set before the reset.
- R2: A clock edge with `ref_valid` high sets the usage flag of frame `ref_frame`.
- R3: A sweep begins with the frame under the hand at the time the request is accepted.
- R4: The first frame found with a clear flag is the victim. Its index appears on `pick_frame` and `pick_done` is high for exactly one cycle.
- R5: A frame inspected with its flag set has the flag cleared, and the sweep moves to the next frame in the same cycle.
- R6: After a victim is chosen, the hand rests on the frame after the victim.
- R7: The hand moves from frame FRAMES-1 to frame 0.
- R8: One frame is inspected per cycle. With FRAMES frames and no references during the sweep, `pick_done` rises at most FRAMES+1 clock edges after the edge that accepted the request. It takes exactly FRAMES+1 edges when every flag is set.
- R9: If a reference and a sweep clear hit the same frame on the same edge, the reference wins and the flag stays set.
- R10: A request that arrives while a sweep is running is ignored. It neither restarts nor queues a sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Marks a frame access this cycle |
| ref_frame | input | IDX_W | Index of the accessed frame |
| pick_req | input | 1 | Start a victim sweep; taken only when idle |
| pick_done | output | 1 | One-cycle pulse: victim index is valid |
| pick_frame | output | IDX_W | Index of the chosen victim, registered |

## Verification
The sweep is tried with several flag patterns:
- **No flags set.** The victim is the frame under the hand, which separates the start point from a fixed frame 0.
- **A run of set flags ahead of the hand.** This shows that flags are cleared and skipped.
- **Set flags behind the hand.** This tells a second-chance sweep apart from a plain scan for the lowest clear index.
- **Every flag set.** This forces a full lap, the longest latency and the wrap.

Further cases check the done latency, a reference that collides with a clear on the same frame, and extra requests issued mid-sweep. In each case the outcome is judged from the next victim that the block reports.

// File: rtl/clkrep_pkg.sv
package clkrep_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } sweep_state_t;

endpackage

// File: rtl/refbit_store.sv
module refbit_store #(
  parameter int FRAMES = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);

  logic [FRAMES-1:0] flags_q;

  for (genvar i = 0; i < FRAMES; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flags_q[i] <= 1'b0;
      end else if (set_en && set_idx == IDX_W'(i)) begin
        flags_q[i] <= 1'b1;
      end else if (clr_en && clr_idx == IDX_W'(i)) begin
        flags_q[i] <= 1'b0;
      end
    end
  end

  assign rd_bit = flags_q[rd_idx];

  // R2: an access leaves its frame flagged
  a_r2_ref_sets: assert property (@(posedge clk) disable iff (rst)
    set_en |=> flags_q[$past(set_idx)]);

  // R9: a same-frame clear loses to a reference
  a_r9_ref_wins: assert property (@(posedge clk) disable iff (rst)
    (set_en && clr_en && set_idx == clr_idx) |=> flags_q[$past(clr_idx)]);

  // R5: a clear without a colliding reference drops the flag
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> !flags_q[$past(clr_idx)]);

endmodule

// File: rtl/hand_ring.sv
module hand_ring #(
  parameter int FRAMES = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] hand
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [IDX_W-1:0] hand_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hand_q <= '0;
    end else if (adv) begin
      hand_q <= (hand_q == LAST) ? '0 : hand_q + 1'b1;
    end
  end

  assign hand = hand_q;

  // R7: the ring closes from the last frame back to frame 0
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && hand_q == LAST) |=> hand_q == '0);

  // R5: an idle cycle leaves the hand where it was
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(hand_q));

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clkrep_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             flag_at_hand,
  input  logic [IDX_W-1:0] hand,
  output logic             adv,
  output logic             clr_en,
  output logic             done,
  output logic [IDX_W-1:0] victim
);

  sweep_state_t st_q;
  logic         found;

  always_comb begin
    adv    = (st_q == ST_SCAN);
    clr_en = (st_q == ST_SCAN) && flag_at_hand;
    found  = (st_q == ST_SCAN) && !flag_at_hand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done   <= 1'b0;
      victim <= '0;
    end else begin
      done <= found;
      if (found) begin
        victim <= hand;
      end
      case (st_q)
        ST_IDLE: if (req)   st_q <= ST_SCAN;
        ST_SCAN: if (found) st_q <= ST_IDLE;
        default:            st_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the done pulse lasts a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a request during a running sweep does not end or restart it
  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SCAN && flag_at_hand) |=> (st_q == ST_SCAN && !done));

  // R3: a request taken while idle starts a sweep
  a_r3_start: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && req) |=> st_q == ST_SCAN);

endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
  parameter int FRAMES = 16,
  parameter int IDX_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_frame,
  input  logic             pick_req,
  output logic             pick_done,
  output logic [IDX_W-1:0] pick_frame
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

  logic [IDX_W-1:0] hand;
  logic             flag_at_hand;
  logic             adv;
  logic             clr_en;

  refbit_store #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_en  (ref_valid),
    .set_idx (ref_frame),
    .clr_en  (clr_en),
    .clr_idx (hand),
    .rd_idx  (hand),
    .rd_bit  (flag_at_hand)
  );

  hand_ring #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_hand (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .hand (hand)
  );

  sweep_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .req          (pick_req),
    .flag_at_hand (flag_at_hand),
    .hand         (hand),
    .adv          (adv),
    .clr_en       (clr_en),
    .done         (pick_done),
    .victim       (pick_frame)
  );

  // R6: once a victim is reported, the hand sits on the frame after it
  a_r6_rest_after: assert property (@(posedge clk) disable iff (rst)
    pick_done |-> hand == ((pick_frame == LAST) ? '0 : pick_frame + 1'b1));

  // R1: no done pulse in the cycle after reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    rst |=> !pick_done);

endmodule

// File: tb/test_clock_victim_picker.sv
module test_clock_victim_picker;

  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_valid = 1'b0;
  logic [IW-1:0] ref_frame = '0;
  logic          pick_req = 1'b0;
  logic          pick_done;
  logic [IW-1:0] pick_frame;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  clock_victim_picker #(.FRAMES(N)) i_clock_victim_picker (
    .clk        (clk),
    .rst        (rst),
    .ref_valid  (ref_valid),
    .ref_frame  (ref_frame),
    .pick_req   (pick_req),
    .pick_done  (pick_done),
    .pick_frame (pick_frame)
  );

  // Vector: {op, frame, expected victim}; op 0 = reference, op 1 = pick
  localparam int NV = 25;
  localparam logic [6:0] VEC [NV] = '{
    {1'b1, 3'd0, 3'd0},
    {1'b0, 3'd1, 3'd0}, {1'b0, 3'd2, 3'd0}, {1'b1, 3'd0, 3'd3},
    {1'b0, 3'd4, 3'd0}, {1'b0, 3'd5, 3'd0}, {1'b0, 3'd6, 3'd0},
    {1'b0, 3'd7, 3'd0}, {1'b0, 3'd0, 3'd0}, {1'b1, 3'd0, 3'd1},
    {1'b1, 3'd0, 3'd2},
    {1'b0, 3'd0, 3'd0}, {1'b0, 3'd1, 3'd0}, {1'b0, 3'd2, 3'd0},
    {1'b0, 3'd3, 3'd0}, {1'b0, 3'd4, 3'd0}, {1'b0, 3'd5, 3'd0},
    {1'b0, 3'd6, 3'd0}, {1'b0, 3'd7, 3'd0}, {1'b1, 3'd0, 3'd3},
    {1'b1, 3'd0, 3'd4},
    {1'b0, 3'd7, 3'd0}, {1'b1, 3'd0, 3'd5}, {1'b1, 3'd0, 3'd6},
    {1'b1, 3'd0, 3'd0}
  };

  task automatic check(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_ref(input int f);
    @(negedge clk);
    ref_valid = 1'b1;
    ref_frame = IW'(f);
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic wait_done(output int frame, output int lat);
    lat = 0;
    frame = -1;
    forever begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (pick_done) begin
        frame = int'(pick_frame);
        return;
      end
      if (lat > 100) return;
    end
  endtask

  task automatic do_pick(output int frame, output int lat);
    @(negedge clk);
    pick_req = 1'b1;
    @(negedge clk);
    pick_req = 1'b0;
    wait_done(frame, lat);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int got, lat, extra;
    do_reset();
    check(int'(pick_done), 0, "R1 done low after reset");

    // Table walk: covers R2 R3 R4 R5 R6 R7 (last pick wraps)
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][6] == 1'b0) begin
        do_ref(int'(VEC[v][5:3]));
      end else begin
        do_pick(got, lat);
        check(got, int'(VEC[v][2:0]), $sformatf("R3 R4 R5 R6 R7 vector %0d", v));
      end
    end

    // R1: reset wipes the flags and the hand
    do_ref(0);
    do_ref(1);
    do_reset();
    check(int'(pick_done), 0, "R1 done low");
    do_pick(got, lat);
    check(got, 0, "R1 first victim after reset");
    do_pick(got, lat);
    check(got, 1, "R1 flags cleared by reset");

    // R8: full lap with every flag set, plus the R4 pulse width
    do_reset();
    for (int f = 0; f < N; f++) do_ref(f);
    do_pick(got, lat);
    check(got, 0, "R8 full lap victim");
    check(lat, N + 1, "R8 full lap latency");
    @(negedge clk);
    check(int'(pick_done), 0, "R4 done lasts one cycle");
    do_pick(got, lat);
    check(lat, 1, "R8 clear flag found on first edge");

    // R9: reference held on frame 0 while the sweep clears it
    do_reset();
    for (int f = 0; f < N; f++) do_ref(f);
    @(negedge clk);
    pick_req  = 1'b1;
    ref_valid = 1'b1;
    ref_frame = '0;
    @(negedge clk);
    pick_req = 1'b0;
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    wait_done(got, lat);
    check(got, 1, "R9 reference beats clear");

    // R10: extra requests mid-sweep are dropped
    do_reset();
    for (int f = 0; f < N; f++) do_ref(f);
    @(negedge clk);
    pick_req = 1'b1;
    @(negedge clk);
    pick_req = 1'b0;
    @(negedge clk);
    pick_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    pick_req = 1'b0;
    wait_done(got, lat);
    check(got, 0, "R10 sweep unaffected");
    extra = 0;
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      if (pick_done) extra++;
    end
    check(extra, 0, "R10 no queued sweep");
    do_pick(got, lat);
    check(got, 1, "R10 next sweep from rested hand");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule